// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the pin-side scan fabric of a device. It sits between the core logic and the pads. There is one capture cell per input pin, and a data cell plus an enable cell per output pin. The cells form a serial chain from `tdi_i` to `tdo_o`. Each cell has a shift stage and an update stage. A three-bit mode code comes from the instruction decode. It selects how pads and core are connected, and whether the serial path runs through the chain or through a one-bit bypass stage. The capture, shift and update strobes come from the test-access state machine, and all of them are sampled on `clk`.

Typical use:
- Sample the live pins without disturbing them.
- Preload safe pin values before switching to an external or internal test mode.
- Hold the pins at scanned values while the serial path is shortened.
- Float every output.

Top module: `bscan_chain`

## Requirements
- R1: Mode codes are 0 functional, 1 sample, 2 preload, 3 external test, 4 internal test, 5 clamp and 6 high-impedance. In functional mode (0), `pad_out_o`=`core_out_i`, `pad_oe_o`=`core_oe_i` and `core_in_o`=`pad_in_i`, and the update stage has no effect on any of them.
- R2: When `capture_i` is high in a chain-routed mode (1, 2, 3 or 4), the shift stage loads values as follows. Chain position 0 is nearest `tdo_o`. Position i (i < N_IN) takes `pad_in_i[i]`. Position N_IN+2k takes `core_out_i[k]`. Position N_IN+2k+1 takes `core_oe_i[k]`.
- R3: With `shift_i` high and `capture_i` low in a chain-routed mode, the chain moves one position toward `tdo_o` per clock, and `tdi_i` enters the highest position. In these modes `tdo_o` shows position 0.
- R4: The update stage copies the shift stage only on a clock with `update_i` high in a chain-routed mode. Driven pad values do not change while shifting.
- R5: In sample mode the pads and core stay connected as in R1 while capture and shift run.
- R6: Values shifted and updated in preload mode appear on `pad_out_o`/`pad_oe_o` as soon as the mode changes to external test, with no further update.
- R7: In external test, each output pin drives its data cell's update bit on `pad_out_o` and its enable cell's update bit on `pad_oe_o`, while `core_in_o` follows `pad_in_i`.
- R8: In internal test, `core_in_o[i]` is the update bit of input position i, and the pads are driven from the update stage as in R7.
- R9: In clamp mode the pads are driven from the update stage, which ignores all strobes. `tdo_o` comes from a one-bit bypass stage: capture loads 0, and shift loads `tdi_i`.
- R10: In high-impedance mode every `pad_oe_o` bit is 0, `pad_out_o` follows `core_out_i`, the serial path uses the bypass stage of R9, and the update stage ignores all strobes.
- R11: Synchronous reset clears the shift stage, update stage and bypass stage, so `tdo_o` is 0 after reset. When both strobes are high, capture takes priority over shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Mode code from instruction decode |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| core_out_i | input | N_OUT | Core output data |
| core_oe_i | input | N_OUT | Core output enables |
| core_in_o | output | N_IN | Values presented to core inputs |
| pad_in_i | input | N_IN | Values from input pads |
| pad_out_o | output | N_OUT | Drive values to output pads |
| pad_oe_o | output | N_OUT | Enables to output pads |

## Verification
A corrupted shift-stage bit stays hidden until it reaches position 0. It then appears on `tdo_o` after as many shifts as its distance from the output, so each captured frame is shifted fully out and compared bit by bit. A corrupted update-stage bit appears on the pads at once, but only in the external-test, internal-test and clamp modes. It appears on `core_in_o` only in internal test. The reference model is therefore compared on every clock across every mode, including the update-stage value carried over from preload. A bypass fault appears on `tdo_o` one clock after the shift that should have loaded it.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    MODE_FUNC    = 3'd0,
    MODE_SAMPLE  = 3'd1,
    MODE_PRELOAD = 3'd2,
    MODE_EXTEST  = 3'd3,
    MODE_INTEST  = 3'd4,
    MODE_CLAMP   = 3'd5,
    MODE_HIGHZ   = 3'd6
  } bscan_mode_e;

  typedef struct packed {
    logic chain_sel;      // serial path runs through the cells
    logic pad_from_upd;   // pads driven from update stage
    logic core_from_upd;  // core inputs taken from update stage
    logic force_hiz;      // all output enables forced off
  } bscan_ctl_t;

endpackage

// File: rtl/bscan_mode_dec.sv
module bscan_mode_dec
  import bscan_pkg::*;
(
  input  logic [2:0] mode_i,
  output bscan_ctl_t ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (bscan_mode_e'(mode_i))
      MODE_SAMPLE, MODE_PRELOAD: ctl_o.chain_sel = 1'b1;
      MODE_EXTEST: begin
        ctl_o.chain_sel    = 1'b1;
        ctl_o.pad_from_upd = 1'b1;
      end
      MODE_INTEST: begin
        ctl_o.chain_sel     = 1'b1;
        ctl_o.pad_from_upd  = 1'b1;
        ctl_o.core_from_upd = 1'b1;
      end
      MODE_CLAMP:  ctl_o.pad_from_upd = 1'b1;
      MODE_HIGHZ:  ctl_o.force_hiz    = 1'b1;
      default:     ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/bscan_in_cell.sv
module bscan_in_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic sh_i,
  input  logic upd_i,
  input  logic pad_i,
  input  logic sin_i,
  output logic sout_o,
  output logic upd_q_o
);

  logic sr_q;
  logic ub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= 1'b0;
      ub_q <= 1'b0;
    end else if (sel_i) begin
      if (cap_i)     sr_q <= pad_i;
      else if (sh_i) sr_q <= sin_i;
      if (upd_i)     ub_q <= sr_q;
    end
  end

  assign sout_o  = sr_q;
  assign upd_q_o = ub_q;

endmodule

// File: rtl/bscan_out_cell.sv
module bscan_out_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic sh_i,
  input  logic upd_i,
  input  logic pad_from_upd_i,
  input  logic force_hiz_i,
  input  logic core_d_i,
  input  logic core_e_i,
  input  logic sin_i,
  output logic mid_o,
  output logic sout_o,
  output logic pad_d_o,
  output logic pad_e_o
);

  logic dat_sr_q, en_sr_q;
  logic dat_ub_q, en_ub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_sr_q <= 1'b0;
      en_sr_q  <= 1'b0;
      dat_ub_q <= 1'b0;
      en_ub_q  <= 1'b0;
    end else if (sel_i) begin
      if (cap_i) begin
        dat_sr_q <= core_d_i;
        en_sr_q  <= core_e_i;
      end else if (sh_i) begin
        en_sr_q  <= sin_i;
        dat_sr_q <= en_sr_q;
      end
      if (upd_i) begin
        dat_ub_q <= dat_sr_q;
        en_ub_q  <= en_sr_q;
      end
    end
  end

  assign mid_o   = en_sr_q;
  assign sout_o  = dat_sr_q;
  assign pad_d_o = pad_from_upd_i ? dat_ub_q : core_d_i;
  assign pad_e_o = force_hiz_i ? 1'b0 : (pad_from_upd_i ? en_ub_q : core_e_i);

endmodule

// File: rtl/bscan_bypass.sv
module bscan_bypass (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic sh_i,
  input  logic tdi_i,
  output logic q_o
);

  logic q;

  always_ff @(posedge clk) begin
    if (rst)                q <= 1'b0;
    else if (sel_i && cap_i) q <= 1'b0;
    else if (sel_i && sh_i)  q <= tdi_i;
  end

  assign q_o = q;

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_OUT-1:0] core_out_i,
  input  logic [N_OUT-1:0] core_oe_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_IN-1:0]  pad_in_i,
  output logic [N_OUT-1:0] pad_out_o,
  output logic [N_OUT-1:0] pad_oe_o
);

  localparam int CHAIN_LEN = N_IN + 2 * N_OUT;

  bscan_ctl_t            ctl;
  logic [CHAIN_LEN:0]    link;
  logic [N_IN-1:0]       in_upd;
  logic                  byp_q;

  assign link[CHAIN_LEN] = tdi_i;

  bscan_mode_dec i_dec (
    .mode_i (mode_i),
    .ctl_o  (ctl)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    bscan_in_cell i_cell (
      .clk     (clk),
      .rst     (rst),
      .sel_i   (ctl.chain_sel),
      .cap_i   (capture_i),
      .sh_i    (shift_i),
      .upd_i   (update_i),
      .pad_i   (pad_in_i[i]),
      .sin_i   (link[i+1]),
      .sout_o  (link[i]),
      .upd_q_o (in_upd[i])
    );
    assign core_in_o[i] = ctl.core_from_upd ? in_upd[i] : pad_in_i[i];
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = N_IN + 2 * k;
    bscan_out_cell i_cell (
      .clk            (clk),
      .rst            (rst),
      .sel_i          (ctl.chain_sel),
      .cap_i          (capture_i),
      .sh_i           (shift_i),
      .upd_i          (update_i),
      .pad_from_upd_i (ctl.pad_from_upd),
      .force_hiz_i    (ctl.force_hiz),
      .core_d_i       (core_out_i[k]),
      .core_e_i       (core_oe_i[k]),
      .sin_i          (link[BASE+2]),
      .mid_o          (link[BASE+1]),
      .sout_o         (link[BASE]),
      .pad_d_o        (pad_out_o[k]),
      .pad_e_o        (pad_oe_o[k])
    );
  end

  bscan_bypass i_byp (
    .clk   (clk),
    .rst   (rst),
    .sel_i (~ctl.chain_sel),
    .cap_i (capture_i),
    .sh_i  (shift_i),
    .tdi_i (tdi_i),
    .q_o   (byp_q)
  );

  assign tdo_o = ctl.chain_sel ? link[0] : byp_q;

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode_i,
  input logic             capture_i,
  input logic             shift_i,
  input logic             update_i,
  input logic             tdi_i,
  input logic             tdo_o,
  input logic [N_OUT-1:0] core_out_i,
  input logic [N_OUT-1:0] core_oe_i,
  input logic [N_IN-1:0]  core_in_o,
  input logic [N_IN-1:0]  pad_in_i,
  input logic [N_OUT-1:0] pad_out_o,
  input logic [N_OUT-1:0] pad_oe_o
);

  // R1
  p_func_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd0) |->
      (pad_out_o == core_out_i && pad_oe_o == core_oe_i && core_in_o == pad_in_i));

  // R5
  p_sample_live_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd1) |->
      (pad_out_o == core_out_i && pad_oe_o == core_oe_i && core_in_o == pad_in_i));

  // R4
  p_pins_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd3 && $past(mode_i) == 3'd3 && !$past(update_i)) |->
      ($stable(pad_out_o) && $stable(pad_oe_o)));

  // R7
  p_extest_core_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd3) |-> (core_in_o == pad_in_i));

  // R9
  p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd5 && $past(mode_i) == 3'd5 && $past(shift_i) && !$past(capture_i))
      |-> (tdo_o == $past(tdi_i)));

  // R10
  p_highz_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'd6) |-> (pad_oe_o == '0));

  // R11
  p_reset_tdo_r11: assert property (@(posedge clk)
    rst |=> (tdo_o == 1'b0));

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) i_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .capture_i(capture_i),
  .shift_i(shift_i), .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
  .core_out_i(core_out_i), .core_oe_i(core_oe_i), .core_in_o(core_in_o),
  .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
);

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;

  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + 2 * NO;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    mode;
  logic          cap, sh, upd, tdi;
  logic          tdo;
  logic [NO-1:0] core_out, core_oe, pad_out, pad_oe;
  logic [NI-1:0] core_in, pad_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state
  logic [L-1:0] m_sr, m_upd;
  logic         m_byp;

  always #2.5 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) i_bscan_chain (
    .clk(clk), .rst(rst), .mode_i(mode), .capture_i(cap), .shift_i(sh),
    .update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .core_out_i(core_out),
    .core_oe_i(core_oe), .core_in_o(core_in), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit routed(input logic [2:0] m);
    return (m >= 3'd1 && m <= 3'd4);
  endfunction

  function automatic string mode_req(input logic [2:0] m);
    case (m)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R1";
    endcase
  endfunction

  // behavioural next-state of the reference
  task automatic model_step();
    logic [L-1:0] nsr, nupd;
    logic nbyp;
    nsr = m_sr; nupd = m_upd; nbyp = m_byp;
    if (rst) begin
      nsr = '0; nupd = '0; nbyp = 1'b0;
    end else if (routed(mode)) begin
      if (cap) begin
        for (int i = 0; i < NI; i++) nsr[i] = pad_in[i];
        for (int k = 0; k < NO; k++) begin
          nsr[NI+2*k]   = core_out[k];
          nsr[NI+2*k+1] = core_oe[k];
        end
      end else if (sh) begin
        nsr = {tdi, m_sr[L-1:1]};
      end
      if (upd) nupd = m_sr;
    end else begin
      if (cap)     nbyp = 1'b0;
      else if (sh) nbyp = tdi;
    end
    m_sr = nsr; m_upd = nupd; m_byp = nbyp;
  endtask

  task automatic compare_all();
    logic [NO-1:0] e_out, e_oe;
    logic [NI-1:0] e_cin;
    logic          e_tdo;
    bit            from_upd;
    from_upd = (mode == 3'd3 || mode == 3'd4 || mode == 3'd5);
    for (int k = 0; k < NO; k++) begin
      e_out[k] = from_upd ? m_upd[NI+2*k] : core_out[k];
      e_oe[k]  = (mode == 3'd6) ? 1'b0 : (from_upd ? m_upd[NI+2*k+1] : core_oe[k]);
    end
    for (int i = 0; i < NI; i++) e_cin[i] = (mode == 3'd4) ? m_upd[i] : pad_in[i];
    e_tdo = routed(mode) ? m_sr[0] : m_byp;
    chk(pad_out === e_out, mode_req(mode), 32'(pad_out), 32'(e_out));
    chk(pad_oe  === e_oe,  mode_req(mode), 32'(pad_oe),  32'(e_oe));
    chk(core_in === e_cin, mode_req(mode), 32'(core_in), 32'(e_cin));
    chk(tdo === e_tdo, routed(mode) ? "R3" : "R9", 32'(tdo), 32'(e_tdo));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobes(input logic c, input logic s, input logic u);
    cap = c; sh = s; upd = u;
  endtask

  // shift v[0] first so that v[j] lands at position j
  task automatic load_chain(input logic [L-1:0] v);
    for (int j = 0; j < L; j++) begin
      strobes(0, 1, 0); tdi = v[j];
      tick();
    end
    strobes(0, 0, 0);
  endtask

  task automatic pulse_update();
    strobes(0, 0, 1); tick(); strobes(0, 0, 0);
  endtask

  initial begin
    logic [L-1:0] frame, exp_frame, pat;
    logic [NO-1:0] held_out, held_oe;
    rst = 1'b1; mode = 3'd3; strobes(0, 0, 0); tdi = 1'b0;
    core_out = '0; core_oe = '0; pad_in = '0;
    m_sr = '0; m_upd = '0; m_byp = 1'b0;
    @(negedge clk);
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R11: reset state visible on pads and tdo
    chk(pad_out === '0 && pad_oe === '0, "R11", 32'({pad_out, pad_oe}), 32'h0);
    chk(tdo === 1'b0, "R11", 32'(tdo), 32'h0);

    // R1: functional, strobes have no effect on pins
    mode = 3'd0;
    for (int n = 0; n < 20; n++) begin
      core_out = 4'($urandom); core_oe = 4'($urandom); pad_in = 4'($urandom);
      strobes(1'($urandom), 1'($urandom), 1'($urandom)); tdi = 1'($urandom);
      tick();
      chk(pad_out === core_out && core_in === pad_in, "R1", 32'(pad_out), 32'(core_out));
    end
    strobes(0, 0, 0);

    // R2 / R5: sample capture then shift out the whole frame
    mode = 3'd1;
    pad_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b1100;
    strobes(1, 1, 0); tick(); strobes(0, 0, 0);  // both strobes: capture wins (R11)
    for (int i = 0; i < NI; i++) exp_frame[i] = pad_in[i];
    for (int k = 0; k < NO; k++) begin
      exp_frame[NI+2*k] = core_out[k]; exp_frame[NI+2*k+1] = core_oe[k];
    end
    for (int j = 0; j < L; j++) begin
      frame[j] = tdo;
      strobes(0, 1, 0); tdi = 1'b0; tick();
      chk(pad_out === core_out, "R5", 32'(pad_out), 32'(core_out));
    end
    strobes(0, 0, 0);
    chk(frame === exp_frame, "R2", 32'(frame), 32'(exp_frame));

    // R6: preload then switch to external test
    mode = 3'd2;
    pat = 12'b10_01_11_00_0110;
    load_chain(pat);
    pulse_update();
    mode = 3'd3;
    tick();
    for (int k = 0; k < NO; k++) begin
      chk(pad_out[k] === pat[NI+2*k] && pad_oe[k] === pat[NI+2*k+1], "R6",
          32'({pad_out[k], pad_oe[k]}), 32'({pat[NI+2*k], pat[NI+2*k+1]}));
    end

    // R4: shifting in external test does not move the pins
    held_out = pad_out; held_oe = pad_oe;
    pat = 12'b01_10_00_11_1001;
    for (int j = 0; j < L; j++) begin
      strobes(0, 1, 0); tdi = pat[j]; tick();
      chk(pad_out === held_out && pad_oe === held_oe, "R4",
          32'({pad_out, pad_oe}), 32'({held_out, held_oe}));
    end
    strobes(0, 0, 0);
    pulse_update();
    for (int k = 0; k < NO; k++)
      chk(pad_out[k] === pat[NI+2*k], "R7", 32'(pad_out[k]), 32'(pat[NI+2*k]));
    pad_in = 4'b0101; tick();
    chk(core_in === 4'b0101, "R7", 32'(core_in), 32'h5);

    // R8: internal test drives core inputs from the chain
    mode = 3'd4;
    pat = 12'b11_00_10_01_0011;
    load_chain(pat);
    pulse_update();
    chk(core_in === pat[NI-1:0], "R8", 32'(core_in), 32'(pat[NI-1:0]));
    core_out = 4'b1001; core_oe = 4'b0011;
    strobes(1, 0, 0); tick(); strobes(0, 0, 0);

    // R9: clamp holds pins, bypass carries tdi with one stage
    mode = 3'd5;
    tick();
    held_out = pad_out; held_oe = pad_oe;
    for (int j = 0; j < 16; j++) begin
      tdi = 1'($urandom);
      strobes(0, 1, 1'($urandom)); tick();
      chk(tdo === tdi, "R9", 32'(tdo), 32'(tdi));
      chk(pad_out === held_out && pad_oe === held_oe, "R9",
          32'({pad_out, pad_oe}), 32'({held_out, held_oe}));
    end
    strobes(1, 0, 0); tick(); strobes(0, 0, 0);
    chk(tdo === 1'b0, "R9", 32'(tdo), 32'h0);

    // R10: high impedance
    mode = 3'd6; core_oe = '1;
    tick();
    chk(pad_oe === '0, "R10", 32'(pad_oe), 32'h0);

    // mixed random traffic across all modes
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) mode = 3'($urandom_range(0, 6));
      core_out = 4'($urandom); core_oe = 4'($urandom); pad_in = 4'($urandom);
      strobes(($urandom % 8) == 0, 1'($urandom), ($urandom % 6) == 0);
      tdi = 1'($urandom);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule